// File: doc/BRIEF.md
# CAN FD Transmitter Delay Compensator

This block places the secondary sample point that a CAN FD node uses to sample its own received bits while it transmits in the fast data phase. At high data rates the transceiver loop delay, from the TX line to the RX line, can be longer than a bit. Sampling at the normal point would then read the previous bit. All quantities here are counted in raw clock periods, not in time quanta.

In automatic mode the block measures the loop delay once per frame. A trigger pulse that coincides with a falling TX edge starts the count, and the first falling RX edge stops it. The compensated position is that delay plus a configured offset. In manual mode a fixed delay from configuration is used in place of the measured one. A filter window can reject a compensated position that is too early. In that case, and when compensation is off, a per-bit strobe is still produced, at the normal sample position supplied by the caller.

Each data-phase bit is announced by a one-cycle bit-start pulse. The block emits exactly one single-cycle strobe per bit at the chosen position. It also reports the latched delay, whether compensation applies to the current bit, and whether the two mode bits were set together.

Top module: `fd_delay_comp`

## Requirements
- R1: A synchronous active-high reset clears `delay_o` to 0 and drives `ssp_o`, `comp_active_o` and `cfg_err_o` low.
- R2: With only `auto_en_i` set, a cycle in which `meas_trig_i` is high, `tx_i` is 0 and `tx_i` was 1 in the previous cycle starts a measurement. The first later cycle in which `rx_i` is 0 after being 1 ends it. `delay_o` then equals the number of clock cycles between those two sampling edges, and shows the new value from the cycle after the RX edge is sampled.
- R3: If no falling RX edge arrives within `SAT_LIMIT` cycles of the start, `delay_o` becomes `SAT_LIMIT`. `delay_o` never exceeds `SAT_LIMIT`.
- R4: A trigger is ignored if it comes without a falling TX edge, or while the mode is anything other than automatic-only.
- R5: `delay_o` changes only when a measurement completes. RX activity with no measurement running leaves it unchanged.
- R6: In manual-only mode the position P equals `cfg_delay_i + cfg_offset_i`.
- R7: In automatic-only mode the position P equals `delay_o + cfg_offset_i`, and `cfg_delay_i` has no effect.
- R8: In automatic-only mode, when `cfg_filter_i > cfg_offset_i` and the sum from R7 is below `cfg_filter_i`, P equals `nom_sp_i` and `comp_active_o` is 0 for that bit.
- R9: The filter window has no effect in manual-only mode, or when `cfg_filter_i <= cfg_offset_i`.
- R10: When neither mode bit is set, P equals `nom_sp_i` and `comp_active_o` is 0. The offset, delay and filter inputs have no effect.
- R11: When both mode bits are set, `cfg_err_o` is high from the cycle after, and the bit is handled as in R10.
- R12: If `bit_start_i` is sampled at edge b, `ssp_o` is high for exactly the one cycle that begins at edge b+P. It does not rise again before the next bit start.
- R13: `comp_active_o` is updated at each bit-start edge and holds its value for the rest of the bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_i | input | 1 | Transmitted bit stream, 0 is dominant |
| rx_i | input | 1 | Received bit stream, 0 is dominant |
| bit_start_i | input | 1 | One-cycle pulse at the start of each data-phase bit |
| meas_trig_i | input | 1 | Pulse marking the TX edge that starts a delay measurement |
| auto_en_i | input | 1 | Selects the measured delay |
| man_en_i | input | 1 | Selects the configured delay |
| cfg_delay_i | input | DW | Fixed delay for manual mode, in clock periods |
| cfg_offset_i | input | DW | Offset added to the delay, in clock periods |
| cfg_filter_i | input | DW | Minimum compensated position, in clock periods |
| nom_sp_i | input | DW | Normal sample position, in clock periods |
| ssp_o | output | 1 | Single-cycle sample strobe |
| delay_o | output | DW | Latched measured delay |
| comp_active_o | output | 1 | Compensation applies to the current bit |
| cfg_err_o | output | 1 | Both mode bits were set |

## Verification
The bench aims at the places where an off-by-one would move the strobe. It checks a trigger and an RX edge one cycle apart, a delay that reaches the saturation limit, and a position of zero. A design that counts from the wrong edge, or registers once too often, would put the strobe one cycle early or late. A design with no clamp would report a delay above the limit. The filter is driven exactly at its limit, with the sum equal to the filter value, and also in manual mode and with a filter no larger than the offset. A design that compares the wrong way round, or filters in the wrong mode, would fall back to the normal position when it should not. Triggers without a falling TX edge, triggers outside automatic mode, and free RX toggling each have to leave the latched delay alone. The conflicting-mode case has to raise the error flag and still place the strobe at the normal position.

// File: rtl/fdc_pkg.sv
package fdc_pkg;
    typedef enum logic [1:0] {
        MODE_OFF  = 2'd0,
        MODE_AUTO = 2'd1,
        MODE_MAN  = 2'd2,
        MODE_BAD  = 2'd3
    } fdc_mode_e;
endpackage

// File: rtl/fdc_mode_dec.sv
module fdc_mode_dec
    import fdc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      auto_en_i,
    input  logic      man_en_i,
    output fdc_mode_e mode_o,
    output logic      cfg_err_o
);
    typedef struct packed {
        logic cfg_err;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        unique case ({man_en_i, auto_en_i})
            2'b01:   mode_o = MODE_AUTO;
            2'b10:   mode_o = MODE_MAN;
            2'b11:   mode_o = MODE_BAD;
            default: mode_o = MODE_OFF;
        endcase
        st_d         = st_q;
        st_d.cfg_err = (mode_o == MODE_BAD);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign cfg_err_o = st_q.cfg_err;
endmodule

// File: rtl/fdc_delay_meter.sv
module fdc_delay_meter #(
    parameter int unsigned DW        = 8,
    parameter int unsigned SAT_LIMIT = 200
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_i,
    input  logic          trig_i,
    input  logic          tx_i,
    input  logic          rx_i,
    output logic [DW-1:0] delay_o,
    output logic          done_o
);
    localparam logic [DW-1:0] SAT_V   = SAT_LIMIT[DW-1:0];
    localparam logic [DW-1:0] CNT_ONE = 1;

    typedef struct packed {
        logic          running;
        logic [DW-1:0] cnt;
        logic [DW-1:0] delay;
        logic          done;
        logic          tx_prev;
        logic          rx_prev;
    } st_t;

    st_t  st_d, st_q;
    logic tx_fall, rx_fall;

    always_comb begin
        tx_fall      = st_q.tx_prev & ~tx_i;
        rx_fall      = st_q.rx_prev & ~rx_i;
        st_d         = st_q;
        st_d.done    = 1'b0;
        st_d.tx_prev = tx_i;
        st_d.rx_prev = rx_i;
        if (en_i && trig_i && tx_fall) begin
            st_d.running = 1'b1;
            st_d.cnt     = CNT_ONE;
        end else if (st_q.running) begin
            if (rx_fall) begin
                st_d.running = 1'b0;
                st_d.delay   = st_q.cnt;
                st_d.done    = 1'b1;
            end else if (st_q.cnt >= SAT_V) begin
                st_d.running = 1'b0;
                st_d.delay   = SAT_V;
                st_d.done    = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + CNT_ONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q         <= '0;
            st_q.tx_prev <= 1'b1;
            st_q.rx_prev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign delay_o = st_q.delay;
    assign done_o  = st_q.done;
endmodule

// File: rtl/fdc_ssp_gen.sv
module fdc_ssp_gen
    import fdc_pkg::*;
#(
    parameter int unsigned DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_start_i,
    input  fdc_mode_e     mode_i,
    input  logic [DW-1:0] meas_dly_i,
    input  logic [DW-1:0] cfg_dly_i,
    input  logic [DW-1:0] off_i,
    input  logic [DW-1:0] filt_i,
    input  logic [DW-1:0] nom_i,
    output logic          ssp_o,
    output logic          comp_o
);
    localparam int unsigned   PW      = DW + 2;
    localparam logic [PW-1:0] POS_ONE = 1;
    localparam logic [PW-1:0] POS_MAX = '1;

    typedef struct packed {
        logic [PW-1:0] pos;
        logic [PW-1:0] tgt;
        logic          armed;
        logic          comp;
        logic          ssp;
    } st_t;

    st_t           st_d, st_q;
    logic [DW-1:0] dly_sel;
    logic [DW:0]   sum;
    logic          filt_hit;
    logic          comp_now;
    logic [PW-1:0] tgt_now;
    logic [PW-1:0] pos_nx;

    always_comb begin
        dly_sel  = (mode_i == MODE_AUTO) ? meas_dly_i : cfg_dly_i;
        sum      = {1'b0, dly_sel} + {1'b0, off_i};
        filt_hit = (mode_i == MODE_AUTO) && (filt_i > off_i) && (sum < {1'b0, filt_i});
        comp_now = ((mode_i == MODE_AUTO) || (mode_i == MODE_MAN)) && !filt_hit;
        tgt_now  = comp_now ? {1'b0, sum} : {2'b00, nom_i};
        pos_nx   = (st_q.pos == POS_MAX) ? st_q.pos : st_q.pos + POS_ONE;

        st_d     = st_q;
        st_d.ssp = 1'b0;
        if (bit_start_i) begin
            st_d.pos   = '0;
            st_d.tgt   = tgt_now;
            st_d.comp  = comp_now;
            st_d.ssp   = (tgt_now == '0);
            st_d.armed = (tgt_now != '0);
        end else begin
            st_d.pos = pos_nx;
            if (st_q.armed && (pos_nx == st_q.tgt)) begin
                st_d.ssp   = 1'b1;
                st_d.armed = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign ssp_o  = st_q.ssp;
    assign comp_o = st_q.comp;
endmodule

// File: rtl/fd_delay_comp.sv
module fd_delay_comp
    import fdc_pkg::*;
#(
    parameter int unsigned DW        = 8,
    parameter int unsigned SAT_LIMIT = 200
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tx_i,
    input  logic          rx_i,
    input  logic          bit_start_i,
    input  logic          meas_trig_i,
    input  logic          auto_en_i,
    input  logic          man_en_i,
    input  logic [DW-1:0] cfg_delay_i,
    input  logic [DW-1:0] cfg_offset_i,
    input  logic [DW-1:0] cfg_filter_i,
    input  logic [DW-1:0] nom_sp_i,
    output logic          ssp_o,
    output logic [DW-1:0] delay_o,
    output logic          comp_active_o,
    output logic          cfg_err_o
);
    fdc_mode_e     mode;
    logic [DW-1:0] meas_dly;
    logic          meas_done;

    fdc_mode_dec u_mode (
        .clk       (clk),
        .rst       (rst),
        .auto_en_i (auto_en_i),
        .man_en_i  (man_en_i),
        .mode_o    (mode),
        .cfg_err_o (cfg_err_o)
    );

    fdc_delay_meter #(.DW(DW), .SAT_LIMIT(SAT_LIMIT)) u_meter (
        .clk     (clk),
        .rst     (rst),
        .en_i    (mode == MODE_AUTO),
        .trig_i  (meas_trig_i),
        .tx_i    (tx_i),
        .rx_i    (rx_i),
        .delay_o (meas_dly),
        .done_o  (meas_done)
    );

    fdc_ssp_gen #(.DW(DW)) u_ssp (
        .clk         (clk),
        .rst         (rst),
        .bit_start_i (bit_start_i),
        .mode_i      (mode),
        .meas_dly_i  (meas_dly),
        .cfg_dly_i   (cfg_delay_i),
        .off_i       (cfg_offset_i),
        .filt_i      (cfg_filter_i),
        .nom_i       (nom_sp_i),
        .ssp_o       (ssp_o),
        .comp_o      (comp_active_o)
    );

    assign delay_o = meas_dly;
endmodule

// File: rtl/fd_delay_comp_chk.sv
module fd_delay_comp_chk #(
    parameter int unsigned DW        = 8,
    parameter int unsigned SAT_LIMIT = 200
) (
    input logic          clk,
    input logic          rst,
    input logic          bit_start_i,
    input logic          auto_en_i,
    input logic          man_en_i,
    input logic          ssp_o,
    input logic          comp_active_o,
    input logic          cfg_err_o,
    input logic [DW-1:0] delay_o,
    input logic          meas_done
);
    logic       past_ok = 1'b0;
    logic [1:0] strobes_q;

    always_ff @(posedge clk) begin
        past_ok <= 1'b1;
        if (rst || bit_start_i) strobes_q <= 2'd0;
        else if (ssp_o && strobes_q != 2'd3) strobes_q <= strobes_q + 2'd1;
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        past_ok && $past(rst) |-> (delay_o == '0) && !comp_active_o && !ssp_o && !cfg_err_o);

    p_sat_bound_r3: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (delay_o <= SAT_LIMIT[DW-1:0]));

    p_delay_hold_r5: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(rst) && !meas_done |-> $stable(delay_o));

    p_err_flag_r11: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(rst) |-> (cfg_err_o == $past(auto_en_i && man_en_i)));

    p_err_no_comp_r11: assert property (@(posedge clk) disable iff (rst)
        bit_start_i && auto_en_i && man_en_i |=> !comp_active_o);

    p_strobe_pulse_r12: assert property (@(posedge clk) disable iff (rst)
        ssp_o |=> !ssp_o);

    p_strobe_once_r12: assert property (@(posedge clk) disable iff (rst)
        past_ok |-> (strobes_q < 2'd2));

    p_comp_hold_r13: assert property (@(posedge clk) disable iff (rst)
        past_ok && !$past(rst) && !$past(bit_start_i) |-> $stable(comp_active_o));
endmodule

bind fd_delay_comp fd_delay_comp_chk #(.DW(DW), .SAT_LIMIT(SAT_LIMIT)) chk_i (
    .clk           (clk),
    .rst           (rst),
    .bit_start_i   (bit_start_i),
    .auto_en_i     (auto_en_i),
    .man_en_i      (man_en_i),
    .ssp_o         (ssp_o),
    .comp_active_o (comp_active_o),
    .cfg_err_o     (cfg_err_o),
    .delay_o       (delay_o),
    .meas_done     (meas_done)
);

// File: tb/fd_delay_comp_tb_top.sv
module fd_delay_comp_tb_top;
    localparam int DW  = 8;
    localparam int SAT = 200;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          tx = 1'b1, rx = 1'b1, bstart = 1'b0, trig = 1'b0;
    logic          a_en = 1'b0, m_en = 1'b0;
    logic [DW-1:0] cdly = '0, off = '0, filt = '0, nom = 8'd1;
    logic          ssp, comp, cerr;
    logic [DW-1:0] dly;

    int n_chk = 0;
    int n_err = 0;
    int exp_meas = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    fd_delay_comp #(.DW(DW), .SAT_LIMIT(SAT)) dut_i (
        .clk(clk), .rst(rst), .tx_i(tx), .rx_i(rx), .bit_start_i(bstart),
        .meas_trig_i(trig), .auto_en_i(a_en), .man_en_i(m_en),
        .cfg_delay_i(cdly), .cfg_offset_i(off), .cfg_filter_i(filt), .nom_sp_i(nom),
        .ssp_o(ssp), .delay_o(dly), .comp_active_o(comp), .cfg_err_o(cerr)
    );

    task automatic chk(string req, int act, int expv);
        n_chk++;
        if (act != expv) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    function automatic bit exp_comp(bit a, bit m, int md, int cd, int o, int f);
        int s;
        if (a == m) return 1'b0;
        s = (a ? md : cd) + o;
        if (a && f > o && s < f) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int exp_pos(bit a, bit m, int md, int cd, int o, int f, int nm);
        if (!exp_comp(a, m, md, cd, o, f)) return nm;
        return (a ? md : cd) + o;
    endfunction

    task automatic measure(int d, string req);
        @(negedge clk); a_en = 1; m_en = 0; tx = 1; rx = 1;
        @(negedge clk); tx = 0; trig = 1;
        for (int i = 1; i <= d; i++) begin
            @(negedge clk);
            if (i == 1) trig = 0;
            if (i == d) rx = 0;
        end
        @(negedge clk);
        exp_meas = d;
        chk(req, int'(dly), d);
        tx = 1; rx = 1;
    endtask

    task automatic run_bit(bit a, bit m, int cd, int o, int f, int nm, string req);
        int p, first, cnt;
        bit ec;
        p  = exp_pos(a, m, exp_meas, cd, o, f, nm);
        ec = exp_comp(a, m, exp_meas, cd, o, f);
        first = 0; cnt = 0;
        @(negedge clk);
        a_en = a; m_en = m; cdly = DW'(cd); off = DW'(o); filt = DW'(f); nom = DW'(nm);
        bstart = 1;
        for (int k = 1; k <= p + 3; k++) begin
            @(negedge clk);
            if (k == 1) begin
                bstart = 0;
                chk({req, " R13 comp"}, int'(comp), int'(ec));
                chk("R11 cfg_err", int'(cerr), int'(a && m));
            end
            if (ssp) begin
                cnt++;
                if (first == 0) first = k;
            end
        end
        chk({req, " strobe cycle"}, first, p + 1);
        chk("R12 strobe count", cnt, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R1 delay", int'(dly), 0);
        chk("R1 comp", int'(comp), 0);
        chk("R1 ssp", int'(ssp), 0);
        chk("R1 cfg_err", int'(cerr), 0);

        // R2 measurement, shortest and typical
        measure(1, "R2 delay=1");
        measure(23, "R2 delay=23");
        // R3 saturation
        @(negedge clk); a_en = 1; tx = 1; rx = 1;
        @(negedge clk); tx = 0; trig = 1;
        @(negedge clk); trig = 0;
        repeat (SAT + 1) @(negedge clk);
        chk("R3 saturate", int'(dly), SAT);
        exp_meas = SAT;
        tx = 1;
        measure(17, "R2 delay=17");

        // R4 trigger with tx already low
        @(negedge clk); tx = 0; rx = 1;
        @(negedge clk); trig = 1;
        @(negedge clk); trig = 0;
        repeat (3) @(negedge clk); rx = 0;
        repeat (3) @(negedge clk);
        chk("R4 no tx edge", int'(dly), 17);
        // R4 trigger in manual mode
        tx = 1; rx = 1; a_en = 0; m_en = 1;
        @(negedge clk); tx = 0; trig = 1;
        @(negedge clk); trig = 0;
        repeat (4) @(negedge clk); rx = 0;
        repeat (3) @(negedge clk);
        chk("R4 manual trig", int'(dly), 17);
        // R5 free rx toggles
        tx = 1; a_en = 1; m_en = 0;
        for (int i = 0; i < 12; i++) begin
            @(negedge clk); rx = ~rx;
        end
        @(negedge clk); rx = 1;
        @(negedge clk);
        chk("R5 hold", int'(dly), 17);

        // directed positions (exp_meas = 17)
        run_bit(0, 1, 30, 5, 0, 9, "R6 manual");
        run_bit(1, 0, 99, 4, 0, 9, "R7 auto ignores cfg delay");
        run_bit(1, 0, 0, 4, 30, 9, "R8 filtered");
        run_bit(1, 0, 0, 4, 21, 9, "R8 sum equals filter");
        run_bit(1, 0, 0, 4, 22, 9, "R8 sum just below filter");
        run_bit(0, 1, 3, 2, 40, 9, "R9 manual no filter");
        run_bit(1, 0, 0, 10, 10, 9, "R9 filter equals offset");
        run_bit(0, 0, 50, 50, 90, 12, "R10 disabled");
        run_bit(1, 1, 5, 5, 0, 14, "R11 both modes");
        run_bit(0, 0, 0, 0, 0, 0, "R12 position zero");
        run_bit(0, 1, 0, 0, 0, 7, "R12 manual zero");

        // mid-run reset clears delay
        @(negedge clk); rst = 1;
        @(negedge clk); rst = 0;
        chk("R1 reset after run", int'(dly), 0);
        exp_meas = 0;

        // constrained random
        for (int it = 0; it < 40; it++) begin
            bit ra, rm;
            if (($urandom % 4) == 0) measure(1 + int'($urandom % 60), "R2 random");
            ra = 1'($urandom % 2);
            rm = 1'($urandom % 2);
            run_bit(ra, rm, int'($urandom % 100), int'($urandom % 60),
                    int'($urandom % 120), 1 + int'($urandom % 80), "R7 R6 R8 random");
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule